// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches recent virtual-to-physical page mappings for a processor pipeline. Every access presents the current address-space identifier, a 32-bit virtual address and a read/write flag. All entries are compared at once against the virtual page number and the identifier. The block then returns the physical address together with the status and permission bits of the matching entry. It also flags a miss, so that a software handler can refill an entry, or a protection fault when a write targets a read-only page. Because every entry carries its own address-space identifier, switching between processes does not require clearing the buffer.

The upper three bits of the virtual address select a region. Two regions are translated through the buffer. The other two map straight to physical memory, cached or uncached, and skip the lookup. Software loads any entry through a write port that names the entry index. The lookup result is registered and appears one cycle after the request. Hits update the referenced and dirty bits of the matching entry. Page-table walking is left to software.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and the result outputs are all zero, so any lookup in a translated region reports a miss until software loads an entry.
- R2: Addresses whose top three bits are 100 (cached) or 101 (uncached) bypass the buffer. They report a hit with a physical address equal to the virtual address with its top three bits cleared. The uncached flag is 1 only for 101. Status outputs are 0.
- R3: Addresses whose top bits are 0xx or 11x are translated. A hit requires a valid entry whose identifier equals the request's identifier and whose 20-bit page field equals address bits 31:12. The physical address is then the entry's 20-bit frame followed by address bits 11:0 unchanged.
- R4: A lookup whose identifier differs from the entry's identifier, or that hits only an invalid entry, reports a miss with a zero physical address.
- R5: A write lookup that matches an entry marked read-only (permission bit 0) reports a fault, with hit and miss both 0 and a zero physical address. The entry's referenced and dirty bits stay unchanged.
- R6: On a hit, the result reports the entry's permission, referenced and dirty bits as they were before this lookup. The lookup then sets the referenced bit, and a write hit also sets the dirty bit. With no matching entry, these outputs are 0.
- R7: When several entries match, the one with the lowest index supplies the result.
- R8: A software load takes effect at the next clock edge. A lookup made in the same cycle as the load sees the entry's previous contents.
- R9: The result is registered. The result-valid output is 1 exactly in the cycle after a lookup request. Hit, miss and fault are all 0 when no result is presented.
- R10: Whenever a result is presented, exactly one of hit, miss and fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_asid | input | 6 | Current address-space identifier |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| sw_we | input | 1 | Software entry load strobe |
| sw_idx | input | 6 | Entry index to load |
| sw_valid | input | 1 | Valid bit to load |
| sw_asid | input | 6 | Identifier to load |
| sw_vpn | input | 20 | Virtual page to load |
| sw_pfn | input | 20 | Physical frame to load |
| sw_rw | input | 1 | Permission to load: 1 read/write, 0 read-only |
| sw_dirty | input | 1 | Dirty bit to load |
| sw_ref | input | 1 | Referenced bit to load |
| rs_valid | output | 1 | Result presented this cycle |
| rs_hit | output | 1 | Translation or bypass succeeded |
| rs_miss | output | 1 | No matching entry |
| rs_fault | output | 1 | Write to read-only page |
| rs_paddr | output | 32 | Physical address (zero unless hit) |
| rs_uncached | output | 1 | Bypass region is uncached |
| rs_rw | output | 1 | Matched entry permission bit |
| rs_ref | output | 1 | Matched entry referenced bit before the lookup |
| rs_dirty | output | 1 | Matched entry dirty bit before the lookup |

## Verification
The hardest situation to reach is two valid entries that match the same page and identifier. Normal refills never create it. The bench loads a deliberate duplicate pair at separated indices, checks that the lower index wins, and then invalidates that entry to expose the higher one. It also covers a lookup issued in the same cycle as a load to the same entry. Beyond that, the bench fills all entries with arithmetically derived pages, frames, identifiers and permissions. It sweeps each entry with read, repeat-read, write, read-back and wrong-identifier accesses, so that the referenced and dirty transitions are seen for every index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int ASID_W = 6;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int SEG_W  = 3;

    typedef enum logic [1:0] {
        RGN_USER_MAP   = 2'd0,
        RGN_KERN_CACHE = 2'd1,
        RGN_KERN_UNCAC = 2'd2,
        RGN_KERN_MAP   = 2'd3
    } region_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic              rw;
        logic              dirty;
        logic              refd;
    } tlb_entry_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            uncached;
        logic            rw;
        logic            dirty;
        logic            refd;
        logic [PA_W-1:0] paddr;
    } tlb_result_t;

    function automatic region_e seg_region(input logic [SEG_W-1:0] top);
        region_e r;
        casez (top)
            3'b0??:  r = RGN_USER_MAP;
            3'b100:  r = RGN_KERN_CACHE;
            3'b101:  r = RGN_KERN_UNCAC;
            default: r = RGN_KERN_MAP;
        endcase
        return r;
    endfunction

    function automatic logic region_mapped(input region_e r);
        return (r == RGN_USER_MAP) || (r == RGN_KERN_MAP);
    endfunction

endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    output region_e          region,
    output logic             mapped,
    output logic             uncached
);
    always_comb begin
        region   = seg_region(seg);
        mapped   = region_mapped(region);
        uncached = (region == RGN_KERN_UNCAC);
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  tlb_entry_t               wr_ent,
    input  logic                     upd_en,
    input  logic [IDX_W-1:0]         upd_idx,
    input  logic                     upd_dirty,
    output tlb_entry_t [ENTRIES-1:0] ent_q
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q[g] <= wr_ent;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                ent_q[g].refd  <= 1'b1;
                ent_q[g].dirty <= ent_q[g].dirty | upd_dirty;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_entry_t [ENTRIES-1:0] ent,
    input  logic [ASID_W-1:0]        asid,
    input  logic [VPN_W-1:0]         vpn,
    output logic                     any,
    output logic [IDX_W-1:0]         idx
);
    logic [ENTRIES-1:0] hitv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hitv[g] = ent[g].valid && (ent[g].asid == asid) && (ent[g].vpn == vpn);
    end

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_valid,
    input  logic [ASID_W-1:0] sw_asid,
    input  logic [VPN_W-1:0]  sw_vpn,
    input  logic [PFN_W-1:0]  sw_pfn,
    input  logic              sw_rw,
    input  logic              sw_dirty,
    input  logic              sw_ref,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_fault,
    output logic [PA_W-1:0]   rs_paddr,
    output logic              rs_uncached,
    output logic              rs_rw,
    output logic              rs_ref,
    output logic              rs_dirty
);
    tlb_entry_t [ENTRIES-1:0] ent_q;
    tlb_entry_t               wr_ent;
    tlb_entry_t               sel;
    region_e                  region;
    logic                     mapped, uncached;
    logic                     m_any;
    logic [IDX_W-1:0]         m_idx;
    logic                     upd_en;
    tlb_result_t              res_d, res_q;

    assign wr_ent = '{valid: sw_valid, asid: sw_asid, vpn: sw_vpn, pfn: sw_pfn,
                      rw: sw_rw, dirty: sw_dirty, refd: sw_ref};

    tlb_seg_decode i_seg (
        .seg      (lk_vaddr[VA_W-1 -: SEG_W]),
        .region   (region),
        .mapped   (mapped),
        .uncached (uncached)
    );

    tlb_match #(.ENTRIES(ENTRIES)) i_match (
        .ent  (ent_q),
        .asid (lk_asid),
        .vpn  (lk_vaddr[VA_W-1 -: VPN_W]),
        .any  (m_any),
        .idx  (m_idx)
    );

    assign sel = ent_q[m_idx];

    always_comb begin
        res_d       = '0;
        res_d.valid = 1'b1;
        if (!mapped) begin
            res_d.hit      = 1'b1;
            res_d.uncached = uncached;
            res_d.paddr    = {{SEG_W{1'b0}}, lk_vaddr[VA_W-SEG_W-1:0]};
        end else if (!m_any) begin
            res_d.miss = 1'b1;
        end else begin
            res_d.rw    = sel.rw;
            res_d.refd  = sel.refd;
            res_d.dirty = sel.dirty;
            if (lk_write && !sel.rw) begin
                res_d.fault = 1'b1;
            end else begin
                res_d.hit   = 1'b1;
                res_d.paddr = {sel.pfn, lk_vaddr[OFF_W-1:0]};
            end
        end
    end

    assign upd_en = lk_valid && mapped && m_any && !(lk_write && !sel.rw);

    tlb_store #(.ENTRIES(ENTRIES)) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sw_we),
        .wr_idx    (sw_idx),
        .wr_ent    (wr_ent),
        .upd_en    (upd_en),
        .upd_idx   (m_idx),
        .upd_dirty (lk_write),
        .ent_q     (ent_q)
    );

    always_ff @(posedge clk) begin
        if (rst)           res_q <= '0;
        else if (lk_valid) res_q <= res_d;
        else               res_q <= '0;
    end

    assign rs_valid    = res_q.valid;
    assign rs_hit      = res_q.hit;
    assign rs_miss     = res_q.miss;
    assign rs_fault    = res_q.fault;
    assign rs_paddr    = res_q.paddr;
    assign rs_uncached = res_q.uncached;
    assign rs_rw       = res_q.rw;
    assign rs_ref      = res_q.refd;
    assign rs_dirty    = res_q.dirty;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            rs_valid,
    input logic            rs_hit,
    input logic            rs_miss,
    input logic            rs_fault,
    input logic [PA_W-1:0] rs_paddr,
    input logic            rs_uncached,
    input logic            rs_rw
);
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |-> !(rs_hit || rs_miss || rs_fault));

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rs_valid);

    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_vaddr[VA_W-1 -: 2] == 2'b10) |=>
            (rs_hit && rs_paddr == {{SEG_W{1'b0}}, $past(lk_vaddr[VA_W-SEG_W-1:0])}));

    p_uncached_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_vaddr[VA_W-1 -: SEG_W] == 3'b101) |=> rs_uncached);

    p_fault_ro_r5: assert property (@(posedge clk) disable iff (rst)
        rs_fault |-> (!rs_rw && rs_paddr == '0));

    p_offset_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_vaddr[VA_W-1 -: 2] != 2'b10) |=>
            (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
endmodule

bind tlb_xlate tlb_xlate_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_vaddr    (lk_vaddr),
    .rs_valid    (rs_valid),
    .rs_hit      (rs_hit),
    .rs_miss     (rs_miss),
    .rs_fault    (rs_fault),
    .rs_paddr    (rs_paddr),
    .rs_uncached (rs_uncached),
    .rs_rw       (rs_rw)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_write, sw_we, sw_valid, sw_rw, sw_dirty, sw_ref;
    logic [5:0]  lk_asid, sw_idx, sw_asid;
    logic [31:0] lk_vaddr;
    logic [19:0] sw_vpn, sw_pfn;
    logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_uncached, rs_rw, rs_ref, rs_dirty;
    logic [31:0] rs_paddr;

    int total = 0;
    int bad   = 0;

    // Bench-side expectation state
    logic        m_valid [N];
    logic [5:0]  m_asid  [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_pfn   [N];
    logic        m_rw    [N];
    logic        m_ref   [N];
    logic        m_dirty [N];

    // expected result of the pending lookup
    logic        e_hit, e_miss, e_fault, e_unc, e_rw, e_ref, e_dirty;
    logic [31:0] e_pa;

    always #4 clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) i_tlb_xlate (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] vpn_of(input int i);
        return ((i % 2) ? 20'hC0000 : 20'h00000) | 20'(i * 37 + 5);
    endfunction
    function automatic logic [19:0] pfn_of(input int i);
        return 20'(i * 1000 + 7);
    endfunction
    function automatic logic [5:0] asid_of(input int i);
        return 6'((i % 4) * 9 + 1);
    endfunction

    // compute expectation from the requirements, then apply side effects (R6)
    task automatic model_lookup(input logic [5:0] asid, input logic [31:0] va, input logic wr);
        logic [2:0] seg;
        int f;
        seg = va[31:29];
        {e_hit, e_miss, e_fault, e_unc, e_rw, e_ref, e_dirty} = '0;
        e_pa = '0;
        if (seg[2] && !seg[1]) begin
            e_hit = 1'b1;
            e_unc = seg[0];
            e_pa  = {3'b000, va[28:0]};
        end else begin
            f = -1;
            for (int i = N - 1; i >= 0; i--)
                if (m_valid[i] && m_asid[i] == asid && m_vpn[i] == va[31:12]) f = i;
            if (f < 0) begin
                e_miss = 1'b1;
            end else begin
                e_rw = m_rw[f]; e_ref = m_ref[f]; e_dirty = m_dirty[f];
                if (wr && !m_rw[f]) begin
                    e_fault = 1'b1;
                end else begin
                    e_hit = 1'b1;
                    e_pa  = {m_pfn[f], va[11:0]};
                    m_ref[f] = 1'b1;
                    if (wr) m_dirty[f] = 1'b1;
                end
            end
        end
    endtask

    task automatic check_result(input string req);
        chk(req, "valid", 32'(rs_valid), 32'd1);
        chk({req, "/R10"}, "hit", 32'(rs_hit), 32'(e_hit));
        chk({req, "/R10"}, "miss", 32'(rs_miss), 32'(e_miss));
        chk({req, "/R10"}, "fault", 32'(rs_fault), 32'(e_fault));
        chk(req, "paddr", rs_paddr, e_pa);
        chk(req, "uncached", 32'(rs_uncached), 32'(e_unc));
        chk(req, "rw", 32'(rs_rw), 32'(e_rw));
        chk(req, "ref", 32'(rs_ref), 32'(e_ref));
        chk(req, "dirty", 32'(rs_dirty), 32'(e_dirty));
    endtask

    task automatic set_load(input int idx, input logic v, input logic [5:0] a,
                            input logic [19:0] vp, input logic [19:0] pf, input logic rw);
        sw_we = 1'b1; sw_idx = 6'(idx); sw_valid = v; sw_asid = a;
        sw_vpn = vp; sw_pfn = pf; sw_rw = rw; sw_dirty = 1'b0; sw_ref = 1'b0;
    endtask

    task automatic apply_load_model(input int idx, input logic v, input logic [5:0] a,
                                    input logic [19:0] vp, input logic [19:0] pf, input logic rw);
        m_valid[idx] = v; m_asid[idx] = a; m_vpn[idx] = vp;
        m_pfn[idx] = pf; m_rw[idx] = rw; m_ref[idx] = 1'b0; m_dirty[idx] = 1'b0;
    endtask

    task automatic load(input int idx, input logic v, input logic [5:0] a,
                        input logic [19:0] vp, input logic [19:0] pf, input logic rw);
        @(negedge clk);
        set_load(idx, v, a, vp, pf, rw);
        @(negedge clk);
        sw_we = 1'b0;
        apply_load_model(idx, v, a, vp, pf, rw);
    endtask

    task automatic lookup(input logic [5:0] asid, input logic [31:0] va, input logic wr, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = asid; lk_vaddr = va; lk_write = wr;
        model_lookup(asid, va, wr);
        @(negedge clk);
        lk_valid = 1'b0;
        check_result(req);
    endtask

    // lookup issued in the same cycle as a load (R8)
    task automatic lookup_with_load(input logic [5:0] asid, input logic [31:0] va, input int idx,
                                    input logic [19:0] pf, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = asid; lk_vaddr = va; lk_write = 1'b0;
        set_load(idx, 1'b1, asid, va[31:12], pf, 1'b1);
        model_lookup(asid, va, 1'b0);
        @(negedge clk);
        lk_valid = 1'b0; sw_we = 1'b0;
        apply_load_model(idx, 1'b1, asid, va[31:12], pf, 1'b1);
        check_result(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_write = 1'b0; lk_asid = '0; lk_vaddr = '0;
        sw_we = 1'b0; sw_idx = '0; sw_valid = 1'b0; sw_asid = '0; sw_vpn = '0;
        sw_pfn = '0; sw_rw = 1'b0; sw_dirty = 1'b0; sw_ref = 1'b0;
        for (int i = 0; i < N; i++) apply_load_model(i, 1'b0, '0, '0, '0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "rs_valid after reset", 32'(rs_valid), 32'd0);
        chk("R1", "rs_paddr after reset", rs_paddr, 32'd0);
        lookup(6'd0, 32'h0000_1234, 1'b0, "R1");
        lookup(6'd1, 32'hC000_5678, 1'b1, "R1");

        // fill every entry
        for (int i = 0; i < N; i++)
            load(i, 1'b1, asid_of(i), vpn_of(i), pfn_of(i), (i % 3) != 0);

        // per-entry sweep: R3 translate, R6 status, R5 protection, R4 identifier
        for (int i = 0; i < N; i++) begin
            logic [31:0] va;
            va = {vpn_of(i), 12'(i * 61 + 3)};
            lookup(asid_of(i), va, 1'b0, "R3");
            lookup(asid_of(i), va, 1'b0, "R6");
            lookup(asid_of(i), va, 1'b1, (i % 3) != 0 ? "R6" : "R5");
            lookup(asid_of(i), va, 1'b0, "R6");
            lookup(asid_of(i) + 6'd1, va, 1'b0, "R4");
        end

        // R2: bypass regions
        for (int k = 0; k < 8; k++) begin
            lookup(6'(k), {3'b100, 29'(k * 32'h0123_4567)}, k[0], "R2");
            lookup(6'(k), {3'b101, 29'(k * 32'h0765_4321 + 9)}, k[1], "R2");
        end

        // R4: invalidated entry misses
        load(5, 1'b0, asid_of(5), vpn_of(5), pfn_of(5), 1'b1);
        lookup(asid_of(5), {vpn_of(5), 12'h0AB}, 1'b0, "R4");

        // R8: same-cycle load sees old contents, next lookup sees new
        lookup_with_load(asid_of(7), {vpn_of(7), 12'h111}, 7, 20'hFEDCB, "R8");
        lookup(asid_of(7), {vpn_of(7), 12'h222}, 1'b0, "R8");

        // R7: duplicate pair, lowest index wins
        load(10, 1'b1, 6'd3, 20'h0ABCD, 20'h11111, 1'b1);
        load(20, 1'b1, 6'd3, 20'h0ABCD, 20'h22222, 1'b1);
        lookup(6'd3, 32'h0ABC_D345, 1'b0, "R7");
        load(10, 1'b0, 6'd3, 20'h0ABCD, 20'h11111, 1'b1);
        lookup(6'd3, 32'h0ABC_D346, 1'b1, "R7");

        // R9: no request -> no result
        @(negedge clk);
        @(negedge clk);
        chk("R9", "rs_valid idle", 32'(rs_valid), 32'd0);
        chk("R9", "outcome idle", 32'({rs_hit, rs_miss, rs_fault}), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule